// File: doc/BRIEF.md
# Dual-Width Working Register File

This block holds the thirty-two 8-bit working registers of a small 8-bit RISC core. In one cycle the core can read two registers as byte operands and write back one byte, or write a 16-bit result into an adjacent register pair. It can also read a register pair as one 16-bit operand. Reads are combinational. Writes take effect at the rising clock edge, so a register that is read in the same cycle as it is written still shows its old value.

The same registers are also mapped into the bottom of the data space. A byte-wide data-space port can read or write register n at address n, for n from 0 to 31. Accesses to any higher address are not for this block: reads from them return zero and writes to them are dropped. When the core and the data-space port write the same register in one cycle, the core write wins.

The top three register pairs are exported all the time as 16-bit pointers for indirect addressing. The lower-numbered register of each pair is the low byte.

Top module: `wreg_file`

## Requirements
- R1: While `rst_n` is low at a rising edge, every register is cleared to zero. After reset, every read path and every pointer output shows zero until something is written.
- R2: `rd_a_data` always equals the register selected by `rd_a_idx`, and `rd_b_data` always equals the register selected by `rd_b_idx`. Both are combinational.
- R3: With `wr_en`=1 and `wr_wide`=0, the register at `wr_idx` takes `wr_data[7:0]` at the rising edge. `wr_data[15:8]` is ignored, and no other register changes.
- R4: With `wr_en`=1 and `wr_wide`=1, bit 0 of `wr_idx` is ignored. The even register of the pair takes `wr_data[7:0]` and the odd register takes `wr_data[15:8]`, both at the same edge.
- R5: `rd_w_data` equals {odd register, even register} of the pair selected by `rd_a_idx`, with bit 0 of `rd_a_idx` ignored.
- R6: A read of a register during the cycle in which it is being written returns the value it held before that edge.
- R7: When `ds_addr` is below 0x20, `ds_rdata` equals register `ds_addr`. For any higher address, `ds_rdata` is zero.
- R8: With `ds_we`=1 and `ds_addr` below 0x20, register `ds_addr` takes `ds_wdata` at the edge. A write to 0x20 or above changes no register, including the register whose index matches the low five address bits.
- R9: If a core write (byte or pair) and a data-space write target the same register in one cycle, that register takes the core value. A data-space write to a different register in the same cycle still completes.
- R10: `ptr_x` = {R27,R26}, `ptr_y` = {R29,R28} and `ptr_z` = {R31,R30} at all times. Each pointer follows a write to either of its registers from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes occur on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 5 | Operand A register index (also selects the pair for the 16-bit read) |
| rd_a_data | output | 8 | Operand A byte |
| rd_b_idx | input | 5 | Operand B register index |
| rd_b_data | output | 8 | Operand B byte |
| rd_w_data | output | 16 | 16-bit pair operand selected by rd_a_idx |
| wr_en | input | 1 | Core write enable |
| wr_wide | input | 1 | 0 = byte write, 1 = register-pair write |
| wr_idx | input | 5 | Core write register index |
| wr_data | input | 16 | Core write data (low byte only for byte writes) |
| ds_addr | input | 16 | Data-space address |
| ds_we | input | 1 | Data-space write enable |
| ds_wdata | input | 8 | Data-space write byte |
| ds_rdata | output | 8 | Data-space read byte (zero outside 0x00–0x1F) |
| ptr_x | output | 16 | Pointer from pair R27:R26 |
| ptr_y | output | 16 | Pointer from pair R29:R28 |
| ptr_z | output | 16 | Pointer from pair R31:R30 |

## Verification
The bench writes pair results through odd indices. A decoder that honoured bit 0 would place the bytes one register too high or drop the low byte. It writes the data space at 0x20 plus each index. A design that decoded only five address bits would overwrite the low registers there, and the full readback that follows catches this. It checks the old value on the read port in the cycle of the write, which exposes a write-through bypass. It also drives core and data-space writes to the same register, both for byte and pair writes. A design with the wrong priority keeps the data-space byte, and a design with a bad pair decode lets the data-space byte win over one half of the pair.

// File: rtl/wrf_pkg.sv
// Shared types for the working register file.
// Assumes: nothing beyond IEEE 1800-2017.
package wrf_pkg;
    // Width of a core write: a single byte or an adjacent register pair.
    typedef enum logic {
        WR_BYTE = 1'b0,
        WR_PAIR = 1'b1
    } wr_width_e;
endpackage

// File: rtl/wrf_store.sv
// Register storage with write arbitration.
// Holds REG_COUNT registers of REG_W bits. A core write (byte or pair) has
// priority over a data-space byte write to the same register. Pair writes
// ignore index bit 0; the even register takes the low byte.
// Assumes: REG_COUNT is even and a power of two; synchronous active-low reset.
module wrf_store
    import wrf_pkg::*;
#(
    parameter int REG_COUNT = 32,
    parameter int REG_W     = 8,
    localparam int IDX_W    = $clog2(REG_COUNT)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            core_en,
    input  wr_width_e                       core_width,
    input  logic [IDX_W-1:0]                core_idx,
    input  logic [2*REG_W-1:0]              core_data,
    input  logic                            ds_en,
    input  logic [IDX_W-1:0]                ds_idx,
    input  logic [REG_W-1:0]                ds_data,
    output logic [REG_COUNT-1:0][REG_W-1:0] regs_q
);

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        logic             core_hit;
        logic [REG_W-1:0] core_byte;

        // Decide whether the core write lands here and which byte it brings.
        always_comb begin
            if (core_width == WR_PAIR) begin
                core_hit  = core_en && (core_idx[IDX_W-1:1] == MY_IDX[IDX_W-1:1]);
                core_byte = MY_IDX[0] ? core_data[2*REG_W-1:REG_W] : core_data[REG_W-1:0];
            end else begin
                core_hit  = core_en && (core_idx == MY_IDX);
                core_byte = core_data[REG_W-1:0];
            end
        end

        // Update this register: reset, then core write, then data-space write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (core_hit) begin
                regs_q[i] <= core_byte;
            end else if (ds_en && (ds_idx == MY_IDX)) begin
                regs_q[i] <= ds_data;
            end
        end
    end

endmodule

// File: rtl/wrf_byte_port.sv
// Combinational byte read port: selects one register by index.
// Assumes: idx is always within range (REG_COUNT is a power of two).
module wrf_byte_port #(
    parameter int REG_COUNT = 32,
    parameter int REG_W     = 8,
    localparam int IDX_W    = $clog2(REG_COUNT)
) (
    input  logic [REG_COUNT-1:0][REG_W-1:0] regs,
    input  logic [IDX_W-1:0]                idx,
    output logic [REG_W-1:0]                data
);

    // Plain index mux.
    always_comb data = regs[idx];

endmodule

// File: rtl/wrf_pair_tap.sv
// Combinational pair read: returns {odd, even} register of the pair chosen
// by pair_sel (a register index with bit 0 dropped).
// Assumes: REG_COUNT is even.
module wrf_pair_tap #(
    parameter int REG_COUNT = 32,
    parameter int REG_W     = 8,
    localparam int IDX_W    = $clog2(REG_COUNT)
) (
    input  logic [REG_COUNT-1:0][REG_W-1:0] regs,
    input  logic [IDX_W-2:0]                pair_sel,
    output logic [2*REG_W-1:0]              data
);

    // Concatenate the two halves, odd register on top.
    always_comb data = {regs[{pair_sel, 1'b1}], regs[{pair_sel, 1'b0}]};

endmodule

// File: rtl/wreg_file.sv
// Dual-width working register file with a data-space alias and pointer export.
// Two byte read ports, one pair read, one byte-or-pair core write port, one
// byte data-space port mapped at addresses 0..REG_COUNT-1, and the top
// PTR_COUNT register pairs exported as address pointers (X lowest).
// Assumes: synchronous active-low reset; reads combinational, writes at edge.
module wreg_file
    import wrf_pkg::*;
#(
    parameter int REG_COUNT = 32,
    parameter int REG_W     = 8,
    parameter int ADDR_W    = 16,
    parameter int PTR_COUNT = 3,
    localparam int IDX_W    = $clog2(REG_COUNT),
    localparam int PW       = 2 * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [REG_W-1:0]  rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [REG_W-1:0]  rd_b_data,
    output logic [PW-1:0]     rd_w_data,
    input  logic              wr_en,
    input  logic              wr_wide,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] ds_addr,
    input  logic              ds_we,
    input  logic [REG_W-1:0]  ds_wdata,
    output logic [REG_W-1:0]  ds_rdata,
    output logic [PW-1:0]     ptr_x,
    output logic [PW-1:0]     ptr_y,
    output logic [PW-1:0]     ptr_z
);

    localparam int FIRST_PTR_PAIR = REG_COUNT / 2 - PTR_COUNT;

    logic [REG_COUNT-1:0][REG_W-1:0] regs_q;
    logic                            ds_hit;
    logic [IDX_W-1:0]                ds_idx;
    logic [REG_W-1:0]                ds_byte;
    logic [PTR_COUNT-1:0][PW-1:0]    ptr_bus;

    // Address decode for the data-space alias window.
    always_comb begin
        ds_hit = ds_addr < ADDR_W'(REG_COUNT);
        ds_idx = ds_addr[IDX_W-1:0];
    end

    wrf_store #(.REG_COUNT(REG_COUNT), .REG_W(REG_W)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_en    (wr_en),
        .core_width (wr_width_e'(wr_wide)),
        .core_idx   (wr_idx),
        .core_data  (wr_data),
        .ds_en      (ds_we && ds_hit),
        .ds_idx     (ds_idx),
        .ds_data    (ds_wdata),
        .regs_q     (regs_q)
    );

    wrf_byte_port #(.REG_COUNT(REG_COUNT), .REG_W(REG_W)) port_a_i (
        .regs (regs_q), .idx (rd_a_idx), .data (rd_a_data)
    );

    wrf_byte_port #(.REG_COUNT(REG_COUNT), .REG_W(REG_W)) port_b_i (
        .regs (regs_q), .idx (rd_b_idx), .data (rd_b_data)
    );

    wrf_byte_port #(.REG_COUNT(REG_COUNT), .REG_W(REG_W)) port_ds_i (
        .regs (regs_q), .idx (ds_idx), .data (ds_byte)
    );

    wrf_pair_tap #(.REG_COUNT(REG_COUNT), .REG_W(REG_W)) pair_a_i (
        .regs (regs_q), .pair_sel (rd_a_idx[IDX_W-1:1]), .data (rd_w_data)
    );

    // Fixed pair taps for the exported pointers.
    for (genvar p = 0; p < PTR_COUNT; p++) begin : g_ptr
        wrf_pair_tap #(.REG_COUNT(REG_COUNT), .REG_W(REG_W)) ptr_tap_i (
            .regs     (regs_q),
            .pair_sel ((IDX_W-1)'(FIRST_PTR_PAIR + p)),
            .data     (ptr_bus[p])
        );
    end

    // Gate the data-space read outside the alias window.
    always_comb ds_rdata = ds_hit ? ds_byte : '0;

    // Name the pointer outputs.
    always_comb begin
        ptr_x = ptr_bus[0];
        ptr_y = ptr_bus[1];
        ptr_z = ptr_bus[PTR_COUNT-1];
    end

endmodule

// File: rtl/wrf_checker.sv
// Protocol checker for wreg_file, bound to every instance of it.
// Assumes: synchronous active-low reset; register state visible as regs_q.
module wrf_checker #(
    parameter int REG_COUNT = 32,
    parameter int REG_W     = 8,
    parameter int ADDR_W    = 16,
    localparam int IDX_W    = $clog2(REG_COUNT),
    localparam int PW       = 2 * REG_W
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic                            wr_wide,
    input logic [IDX_W-1:0]                wr_idx,
    input logic [PW-1:0]                   wr_data,
    input logic [ADDR_W-1:0]               ds_addr,
    input logic                            ds_we,
    input logic [REG_W-1:0]                ds_wdata,
    input logic [REG_W-1:0]                ds_rdata,
    input logic [IDX_W-1:0]                rd_a_idx,
    input logic [PW-1:0]                   rd_w_data,
    input logic [PW-1:0]                   ptr_z,
    input logic [REG_COUNT-1:0][REG_W-1:0] regs_q
);

    localparam logic [IDX_W-2:0] TOP_PAIR = (IDX_W-1)'(REG_COUNT / 2 - 1);

    logic [IDX_W-1:0] wr_even, wr_odd, ds_idx;
    logic             ds_in_win, core_touch;

    // Helper decode used by the properties.
    always_comb begin
        wr_even    = {wr_idx[IDX_W-1:1], 1'b0};
        wr_odd     = {wr_idx[IDX_W-1:1], 1'b1};
        ds_idx     = ds_addr[IDX_W-1:0];
        ds_in_win  = ds_addr < ADDR_W'(REG_COUNT);
        core_touch = wr_en && (wr_wide ? (wr_idx[IDX_W-1:1] == ds_idx[IDX_W-1:1])
                                       : (wr_idx == ds_idx));
    end

    // R3
    byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide) |=> regs_q[$past(wr_idx)] == $past(wr_data[REG_W-1:0]));

    // R4
    pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wide) |=> {regs_q[$past(wr_odd)], regs_q[$past(wr_even)]} == $past(wr_data));

    // R8
    ds_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_we && ds_in_win && !core_touch) |=> regs_q[$past(ds_idx)] == $past(ds_wdata));

    // R9
    core_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide && ds_we && ds_in_win && ds_idx == wr_idx)
        |=> regs_q[$past(wr_idx)] != $past(ds_wdata) || $past(ds_wdata) == $past(wr_data[REG_W-1:0]));

    // R7
    ds_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_in_win |-> ds_rdata == '0);

    // R10
    ptr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx[IDX_W-1:1] == TOP_PAIR) |-> rd_w_data == ptr_z);

endmodule

bind wreg_file wrf_checker #(
    .REG_COUNT (REG_COUNT),
    .REG_W     (REG_W),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_wide   (wr_wide),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .ds_addr   (ds_addr),
    .ds_we     (ds_we),
    .ds_wdata  (ds_wdata),
    .ds_rdata  (ds_rdata),
    .rd_a_idx  (rd_a_idx),
    .rd_w_data (rd_w_data),
    .ptr_z     (ptr_z),
    .regs_q    (regs_q)
);

// File: tb/wreg_file_tb_top.sv
`timescale 1ns/1ps
module wreg_file_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [7:0]  rd_a_data, rd_b_data, ds_wdata, ds_rdata;
    logic [15:0] rd_w_data, wr_data, ds_addr, ptr_x, ptr_y, ptr_z;
    logic        wr_en, wr_wide, ds_we;

    logic [7:0]  mdl [32];
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #2 clk = ~clk;

    wreg_file dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .rd_w_data(rd_w_data),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
        .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Read every register through all paths and compare with the model.
    task automatic sweep_all(input string req);
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i);
            rd_b_idx = 5'(31 - i);
            ds_addr  = 16'(i);
            #0.1;
            chk({req, " R2 port A"}, 16'(rd_a_data), 16'(mdl[i]));
            chk({req, " R2 port B"}, 16'(rd_b_data), 16'(mdl[31 - i]));
            chk({req, " R7 ds read"}, 16'(ds_rdata), 16'(mdl[i]));
            chk({req, " R5 pair read"}, rd_w_data, {mdl[i | 1], mdl[i & 30]});
        end
        chk({req, " R10 ptr_x"}, ptr_x, {mdl[27], mdl[26]});
        chk({req, " R10 ptr_y"}, ptr_y, {mdl[29], mdl[28]});
        chk({req, " R10 ptr_z"}, ptr_z, {mdl[31], mdl[30]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_wide = 1'b0; wr_idx = '0; wr_data = '0;
        ds_addr = '0; ds_we = 1'b0; ds_wdata = '0; rd_a_idx = '0; rd_b_idx = '0;
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything reads zero after reset.
        sweep_all("R1 reset");

        // R3 / R6: byte writes, old value visible in the write cycle.
        for (int i = 0; i < 32; i++) begin
            wr_en = 1'b1; wr_wide = 1'b0; wr_idx = 5'(i);
            wr_data = {8'hA5, 8'(i * 37 + 11)};
            rd_a_idx = 5'(i);
            #0.1;
            chk("R6 old value during write", 16'(rd_a_data), 16'(mdl[i]));
            tick();
            mdl[i] = 8'(i * 37 + 11);
        end
        wr_en = 1'b0;
        sweep_all("R3 byte writes");

        // R4: pair writes through odd indices (bit 0 must be ignored).
        for (int p = 0; p < 16; p++) begin
            wr_en = 1'b1; wr_wide = 1'b1; wr_idx = 5'(2 * p + 1);
            wr_data = 16'(p * 4099 + 16'h1234);
            tick();
            mdl[2 * p]     = wr_data[7:0];
            mdl[2 * p + 1] = wr_data[15:8];
            wr_en = 1'b0;
            rd_a_idx = 5'(2 * p);
            #0.1;
            chk("R4 pair low byte", 16'(rd_a_data), 16'(mdl[2 * p]));
            chk("R4 pair via even index", rd_w_data, 16'(p * 4099 + 16'h1234));
        end
        wr_wide = 1'b0;
        sweep_all("R4 pair writes");

        // R8: data-space writes inside the window.
        for (int i = 0; i < 32; i++) begin
            ds_we = 1'b1; ds_addr = 16'(i); ds_wdata = 8'(i * 13 + 200);
            tick();
            mdl[i] = 8'(i * 13 + 200);
        end
        // R8 / R7: aliased addresses above the window are ignored and read zero.
        for (int i = 0; i < 32; i++) begin
            ds_we = 1'b1; ds_addr = 16'h0020 + 16'(i); ds_wdata = 8'h5A;
            tick();
            ds_we = 1'b0;
            #0.1;
            chk("R7 out-of-window read zero", 16'(ds_rdata), 16'h0000);
        end
        ds_addr = 16'h0100; #0.1;
        chk("R7 high address read zero", 16'(ds_rdata), 16'h0000);
        sweep_all("R8 ds writes");

        // R9: byte conflict, core wins.
        wr_en = 1'b1; wr_wide = 1'b0; wr_idx = 5'd9; wr_data = 16'h0011;
        ds_we = 1'b1; ds_addr = 16'd9; ds_wdata = 8'h22;
        tick();
        mdl[9] = 8'h11;
        // R9: pair conflict on the odd half, core wins both halves.
        wr_wide = 1'b1; wr_idx = 5'd12; wr_data = 16'h3344;
        ds_addr = 16'd13; ds_wdata = 8'h99;
        tick();
        mdl[12] = 8'h44; mdl[13] = 8'h33;
        // R9: different targets both complete.
        wr_wide = 1'b0; wr_idx = 5'd3; wr_data = 16'h00C3;
        ds_addr = 16'd4; ds_wdata = 8'hD4;
        tick();
        mdl[3] = 8'hC3; mdl[4] = 8'hD4;
        // R10: pointer pair written, then data-space byte into Z high.
        wr_wide = 1'b1; wr_idx = 5'd26; wr_data = 16'hBEEF; ds_we = 1'b0;
        tick();
        mdl[26] = 8'hEF; mdl[27] = 8'hBE;
        wr_en = 1'b0; ds_we = 1'b1; ds_addr = 16'd31; ds_wdata = 8'h7E;
        tick();
        mdl[31] = 8'h7E;
        ds_we = 1'b0;
        chk("R10 ptr_x after pair write", ptr_x, 16'hBEEF);
        sweep_all("R9 R10 conflicts and pointers");

        // R1: reset again clears everything.
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        sweep_all("R1 second reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule